// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-visible side of a simple UART peripheral. It sits on a 32-bit, word-oriented bus and holds nine 8-bit registers: a receive buffer and a transmit holding register that share one address, plus interrupt enable, interrupt identification, line control, modem control, line status, modem status and divisor. It tracks whether the transmit holding register is empty and whether a received byte is waiting, and it drives a single interrupt line.

Toward the line side, the block offers one character at a time to an external serializer over a valid/acknowledge pair. It masks that character to the word length selected in line control. It takes received bytes from an external deserializer on a one-cycle valid strobe. Bit timing, modem lines and the baud generator live elsewhere. The divisor, modem control and modem status values are only stored and returned on a read.

The bus uses one-cycle read and write strobes, a byte address, four byte enables and a registered read port. Only a whole-word access to one of the eight mapped word offsets takes effect. Any other access raises a one-cycle error pulse and changes nothing.

Top module: `uart_regfile`

## Requirements
- R1: After reset, line status reads 0x20 (only bit 5 set). Every other register reads 0, and `irq`, `tx_valid` and `bus_err` are low.
- R2: A write to offset 0x00 stores the byte and clears line status bit 5 and interrupt identification bit 1. From the next cycle it raises `tx_valid`, which then holds until `tx_ack`.
- R3: While `tx_valid` is high, `tx_data` is the stored byte ANDed with a mask chosen by line control bits [1:0]: 0 gives 0x1F, 1 gives 0x3F, 2 gives 0x7F and 3 gives 0xFF. The mask follows the current line control value.
- R4: A cycle with `tx_valid` and `tx_ack` both high completes the transfer. On the next cycle `tx_valid` is low, line status bit 5 is set and interrupt identification (offset 0x08) reads 0x02. `irq` is set if interrupt enable bit 1 is set.
- R5: A write to interrupt enable (offset 0x04) with data bit 1 set, while line status bit 5 is set, sets identification bit 1 and asserts `irq` on the next cycle. A write with data bit 1 clear deasserts `irq`. A write with bit 1 set while bit 5 is clear leaves `irq` unchanged.
- R6: A cycle with `rx_valid` high loads `rx_data` into the receive buffer and sets line status bit 0. If interrupt enable bit 0 is set, identification reads 0x04 and `irq` is asserted. If it is clear, `irq` and identification keep their values.
- R7: A read of offset 0x00 returns the receive buffer and clears line status bit 0.
- R8: Writes to offsets 0x08 (identification), 0x0C (line control), 0x10 (modem control), 0x14 (line status), 0x18 (modem status) and 0x1C (divisor) store `wdata[7:0]`. Reads return that value in bits [7:0], and bits [31:8] read as zero.
- R9: An access with `byte_en` other than 4'b1111, a byte address that is not a multiple of 4, or an offset above 0x1C pulses `bus_err` on the next cycle. The access changes no register, and a faulted read returns 0.
- R10: `rdata` changes only on the cycle after a read strobe and holds its value through idle and write cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| addr | input | 8 | Byte address of the access |
| byte_en | input | 4 | Byte enables; only 4'b1111 is legal |
| wdata | input | 32 | Write data; the register value is in bits [7:0] |
| rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an illegal access |
| tx_valid | output | 1 | A character is offered to the serializer |
| tx_data | output | 8 | Character masked to the word length |
| tx_ack | input | 1 | Serializer has taken the character |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Interrupt request |

## Verification
A wrong transmit-empty flag shows up one cycle later in two places: in a line status read, and in whether an interrupt-enable write raises `irq`. A stale pending flag shows up as `tx_valid` staying high after the acknowledge, or never rising after a write. A corrupted identification or receive-ready bit shows up on the next read of offset 0x08 or 0x14. The interrupt line is the only unprompted output, so a wrong `irq` is observed on the cycle after the completion, receive or enable event that should have moved it.

// File: rtl/uart_regs_pkg.sv
// Package: register indices, bit positions and codes shared by the UART
// register front end. Assumes word-spaced registers, index = byte addr / 4.
package uart_regs_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 8;

    // Word indices (byte offset / 4); software decodes these
    localparam int IDX_DATA = 0;  // receive buffer on read, transmit holding on write
    localparam int IDX_IEN  = 1;
    localparam int IDX_IID  = 2;
    localparam int IDX_LCTL = 3;
    localparam int IDX_MCTL = 4;
    localparam int IDX_LSTS = 5;
    localparam int IDX_MSTS = 6;
    localparam int IDX_DIVR = 7;

    // Bit positions
    localparam int IEN_RX_BIT  = 0;
    localparam int IEN_TX_BIT  = 1;
    localparam int LSTS_RX_BIT = 0;
    localparam int LSTS_TX_BIT = 5;
    localparam int IID_TX_BIT  = 1;

    // Identification codes
    localparam logic [REG_W-1:0] CODE_TX_READY = 8'h02;
    localparam logic [REG_W-1:0] CODE_RX_READY = 8'h04;
    localparam logic [REG_W-1:0] LSTS_RESET    = 8'h20;

    // Character mask for a word-length code: 5 + code bits kept
    function automatic logic [REG_W-1:0] char_mask(input logic [1:0] wls);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i < 5 + int'(wls)) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/uart_addr_decode.sv
// Module: uart_addr_decode
// Turns a byte address and byte enables into one-hot read/write hits and
// flags illegal accesses. Assumes strobes are one cycle wide.
module uart_addr_decode #(
    parameter int ADDR_W   = 8,
    parameter int BE_W     = 4,
    parameter int NUM_REGS = 8
) (
    input  logic                wr_stb,
    input  logic                rd_stb,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BE_W-1:0]     byte_en,
    output logic [NUM_REGS-1:0] wr_hit,
    output logic [NUM_REGS-1:0] rd_hit,
    output logic                access_err
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             legal;

    // Legality: full word, aligned, inside the map
    always_comb begin
        word_idx = addr[ADDR_W-1:2];
        legal    = (byte_en == {BE_W{1'b1}}) && (addr[1:0] == 2'b00)
                   && (int'(word_idx) < NUM_REGS);
        access_err = (wr_stb || rd_stb) && !legal;
    end

    // One hit line per register
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign wr_hit[g] = wr_stb && legal && (int'(word_idx) == g);
        assign rd_hit[g] = rd_stb && legal && (int'(word_idx) == g);
    end
endmodule

// File: rtl/uart_tx_handoff.sv
// Module: uart_tx_handoff
// Holds the transmit-pending flag and presents the masked character to the
// serializer until acknowledged. Assumes load and ack may coincide; load wins.
module uart_tx_handoff
    import uart_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] thr,
    input  logic [1:0]       wls,
    input  logic             tx_ack,
    output logic             tx_valid,
    output logic [REG_W-1:0] tx_data,
    output logic             done
);
    logic             pending;
    logic [REG_W-1:0] mask;

    // Pending flag: set by a load, cleared by the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)           pending <= 1'b0;
        else if (load)        pending <= 1'b1;
        else if (tx_ack)      pending <= 1'b0;
    end

    // Masked character and completion strobe
    always_comb begin
        mask     = char_mask(wls);
        tx_valid = pending;
        tx_data  = thr & mask;
        done     = pending && tx_ack;
    end

    // R2: an offered character stays offered until taken
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ack |=> tx_valid);

    // R3: no bit above the word length leaves the block
    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && wls == 2'd0 |-> tx_data[REG_W-1:5] == '0);
endmodule

// File: rtl/uart_read_mux.sv
// Module: uart_read_mux
// Registered read port: selects the hit register, zero-extends it, and
// returns zero on a faulted read. Holds its value between reads.
module uart_read_mux #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 8,
    parameter int DATA_W   = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_stb,
    input  logic                           access_err,
    input  logic [NUM_REGS-1:0]            rd_hit,
    input  logic [NUM_REGS-1:0][REG_W-1:0] regs_in,
    output logic [DATA_W-1:0]              rdata
);
    logic [REG_W-1:0] sel;

    // AND-OR select over one-hot hits
    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_hit[i]) sel = sel | regs_in[i];
        end
    end

    // Capture on a read strobe only
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= access_err ? '0 : {{(DATA_W-REG_W){1'b0}}, sel};
    end

    // R8: upper bits never carry data
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rdata[DATA_W-1:REG_W] == '0);

    // R10: the port holds between reads
    p_hold_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rdata));
endmodule

// File: rtl/uart_regfile.sv
// Module: uart_regfile
// Register and interrupt front end of a UART. Holds the nine byte registers,
// tracks transmit-empty and receive-ready, drives one interrupt line.
// Assumes same-cycle updates apply as: completion, receive-buffer read clear,
// received byte, then bus write (last one wins on a shared field).
module uart_regfile
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        byte_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_err,
    output logic              tx_valid,
    output logic [REG_W-1:0]  tx_data,
    input  logic              tx_ack,
    input  logic              rx_valid,
    input  logic [REG_W-1:0]  rx_data,
    output logic              irq
);
    localparam int BE_W = DATA_W / 8;

    logic [NUM_REGS-1:0]            wr_hit, rd_hit;
    logic                           access_err;
    logic [REG_W-1:0]               rbr, thr, ien, iid, lctl, mctl, lsts, msts, divr;
    logic [REG_W-1:0]               wbyte;
    logic                           tx_done;
    logic [NUM_REGS-1:0][REG_W-1:0] rd_view;

    uart_addr_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W), .NUM_REGS(NUM_REGS)) u_dec (
        .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr), .byte_en(byte_en),
        .wr_hit(wr_hit), .rd_hit(rd_hit), .access_err(access_err));

    uart_tx_handoff u_tx (
        .clk(clk), .rst_n(rst_n), .load(wr_hit[IDX_DATA]), .thr(thr),
        .wls(lctl[1:0]), .tx_ack(tx_ack), .tx_valid(tx_valid),
        .tx_data(tx_data), .done(tx_done));

    // Read view: receive buffer shares word 0 with the holding register
    always_comb begin
        wbyte              = wdata[REG_W-1:0];
        rd_view[IDX_DATA]  = rbr;
        rd_view[IDX_IEN]   = ien;
        rd_view[IDX_IID]   = iid;
        rd_view[IDX_LCTL]  = lctl;
        rd_view[IDX_MCTL]  = mctl;
        rd_view[IDX_LSTS]  = lsts;
        rd_view[IDX_MSTS]  = msts;
        rd_view[IDX_DIVR]  = divr;
    end

    uart_read_mux #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .access_err(access_err),
        .rd_hit(rd_hit), .regs_in(rd_view), .rdata(rdata));

    // Error pulse one cycle after an illegal access
    always_ff @(posedge clk) begin
        if (!rst_n) bus_err <= 1'b0;
        else        bus_err <= access_err;
    end

    // Register state, status flags and interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbr <= '0; thr <= '0; ien <= '0; iid <= '0; lctl <= '0;
            mctl <= '0; lsts <= LSTS_RESET; msts <= '0; divr <= '0;
            irq <= 1'b0;
        end else begin
            if (tx_done) begin
                lsts[LSTS_TX_BIT] <= 1'b1;
                iid               <= CODE_TX_READY;
                if (ien[IEN_TX_BIT]) irq <= 1'b1;
            end
            if (rd_hit[IDX_DATA]) lsts[LSTS_RX_BIT] <= 1'b0;
            if (rx_valid) begin
                rbr               <= rx_data;
                lsts[LSTS_RX_BIT] <= 1'b1;
                if (ien[IEN_RX_BIT]) begin
                    iid <= CODE_RX_READY;
                    irq <= 1'b1;
                end
            end
            if (wr_hit[IDX_DATA]) begin
                thr               <= wbyte;
                lsts[LSTS_TX_BIT] <= 1'b0;
                iid[IID_TX_BIT]   <= 1'b0;
            end
            if (wr_hit[IDX_IEN]) begin
                ien <= wbyte;
                if (wbyte[IEN_TX_BIT] && lsts[LSTS_TX_BIT]) begin
                    iid[IID_TX_BIT] <= 1'b1;
                    irq             <= 1'b1;
                end else if (!wbyte[IEN_TX_BIT]) begin
                    irq <= 1'b0;
                end
            end
            if (wr_hit[IDX_IID])  iid  <= wbyte;
            if (wr_hit[IDX_LCTL]) lctl <= wbyte;
            if (wr_hit[IDX_MCTL]) mctl <= wbyte;
            if (wr_hit[IDX_LSTS]) lsts <= wbyte;
            if (wr_hit[IDX_MSTS]) msts <= wbyte;
            if (wr_hit[IDX_DIVR]) divr <= wbyte;
        end
    end

    // R2: a holding write empties the status and starts the hand-off
    p_thr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit[IDX_DATA] |=> !lsts[LSTS_TX_BIT] && !iid[IID_TX_BIT] && tx_valid);

    // R4: completion restores the empty flag and the ready code
    p_done_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ack && !wr_stb |=> lsts[LSTS_TX_BIT] && iid == CODE_TX_READY && !tx_valid);

    // R4: completion interrupts when enabled
    p_done_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ack && !wr_stb && ien[IEN_TX_BIT] |=> irq);

    // R5: enabling with an empty holding register interrupts at once
    p_ien_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit[IDX_IEN] && wdata[IEN_TX_BIT] && lsts[LSTS_TX_BIT] |=> irq);

    // R5: clearing the transmit enable drops the line
    p_ien_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit[IDX_IEN] && !wdata[IEN_TX_BIT] |=> !irq);

    // R6: a received byte is captured and flagged
    p_rx_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !wr_hit[IDX_LSTS] |=> lsts[LSTS_RX_BIT] && rbr == $past(rx_data));

    // R7: reading the receive buffer clears the ready flag
    p_rx_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit[IDX_DATA] && !rx_valid && !wr_stb |=> !lsts[LSTS_RX_BIT]);

    // R9: an illegal access reports and leaves state alone
    p_err_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |=> bus_err && $stable(ien) && $stable(lctl) && $stable(divr) && $stable(mctl));
endmodule

// File: tb/uart_regfile_tb_top.sv
// Bench for uart_regfile: a driver task issues bus accesses and pushes the
// expected read data and error flag; a monitor pops and compares each result.
module uart_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0]  addr = '0;
    logic [3:0]  byte_en = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        bus_err, tx_valid, irq;
    logic [7:0]  tx_data;
    logic        tx_ack = 1'b0, rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] q_data[$];
    logic        q_err[$];
    logic        q_chk[$];
    string       q_tag[$];
    logic        acc_seen = 1'b0;
    bit          done = 1'b0;

    uart_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .addr(addr), .byte_en(byte_en), .wdata(wdata), .rdata(rdata),
        .bus_err(bus_err), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ack(tx_ack), .rx_valid(rx_valid), .rx_data(rx_data), .irq(irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench flop: an access was presented at this edge
    always @(posedge clk) acc_seen <= rst_n && (wr_stb || rd_stb);

    // Monitor: pop one expectation per access and compare
    always @(negedge clk) begin
        if (acc_seen) begin
            if (q_tag.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL scoreboard: result with no expectation");
            end else begin
                logic [31:0] ed; logic ee; logic ec; string t;
                ed = q_data.pop_front(); ee = q_err.pop_front();
                ec = q_chk.pop_front();  t  = q_tag.pop_front();
                n_vec++;
                if (bus_err !== ee || (ec && rdata !== ed)) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                             t, rdata, bus_err, ed, ee);
                end
            end
        end
    end

    task automatic access(input bit is_wr, input logic [7:0] a, input logic [3:0] be,
                          input logic [31:0] d, input logic [31:0] exp_d,
                          input bit exp_e, input bit chk, input string tag);
        @(negedge clk);
        wr_stb = is_wr; rd_stb = !is_wr; addr = a; byte_en = be; wdata = d;
        q_data.push_back(exp_d); q_err.push_back(exp_e);
        q_chk.push_back(chk);    q_tag.push_back(tag);
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        access(1'b1, a, 4'hF, d, 32'h0, 1'b0, 1'b0, tag);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp_d, input string tag);
        access(1'b0, a, 4'hF, 32'h0, exp_d, 1'b0, 1'b1, tag);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp_v, input string tag);
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic ack_pulse();
        @(negedge clk); tx_ack = 1'b1;
        @(negedge clk); tx_ack = 1'b0;
    endtask

    task automatic rx_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq, 0, "R1 irq");
        chk(tx_valid, 0, "R1 tx_valid");
        chk(bus_err, 0, "R1 bus_err");
        rd(8'h14, 32'h20, "R1 line status");
        rd(8'h04, 32'h00, "R1 enable");
        rd(8'h08, 32'h00, "R1 ident");
        rd(8'h1C, 32'h00, "R1 divisor");

        // R8 store and read back, upper bits zero
        wr(8'h1C, 32'h1234_5678, "R8 div wr");
        rd(8'h1C, 32'h78, "R8 divisor");
        wr(8'h10, 32'hFFFF_FF5A, "R8 mctl wr");
        rd(8'h10, 32'h5A, "R8 modem ctl");
        wr(8'h18, 32'h0000_00C3, "R8 msts wr");
        rd(8'h18, 32'hC3, "R8 modem sts");
        wr(8'h08, 32'h11, "R8 iid wr");
        rd(8'h08, 32'h11, "R8 ident");
        wr(8'h08, 32'h00, "R8 iid clr");
        // R10 hold through idle
        rd(8'h1C, 32'h78, "R10 read");
        repeat (3) @(negedge clk);
        chk(rdata, 32'h78, "R10 held after idle");
        wr(8'h10, 32'h00, "R10 write");
        chk(rdata, 32'h78, "R10 held after write");

        // R2/R3 transmit with 5-bit words
        wr(8'h0C, 32'h0, "R3 lctl 5");
        wr(8'h00, 32'hFF, "R2 thr wr");
        chk(tx_valid, 1, "R2 tx_valid");
        chk(tx_data, 8'h1F, "R3 mask 5");
        rd(8'h14, 32'h00, "R2 empty cleared");
        rd(8'h08, 32'h00, "R2 ident bit cleared");
        chk(tx_valid, 1, "R2 held without ack");
        wr(8'h0C, 32'h1, "R3 lctl 6");
        chk(tx_data, 8'h3F, "R3 mask 6");
        wr(8'h0C, 32'h2, "R3 lctl 7");
        chk(tx_data, 8'h7F, "R3 mask 7");
        wr(8'h0C, 32'h3, "R3 lctl 8");
        chk(tx_data, 8'hFF, "R3 mask 8");

        // R4 completion with interrupt disabled
        ack_pulse();
        chk(tx_valid, 0, "R4 tx_valid dropped");
        chk(irq, 0, "R4 no irq when disabled");
        rd(8'h14, 32'h20, "R4 empty set");
        rd(8'h08, 32'h02, "R4 ready code");

        // R5 enable while empty interrupts at once; clear drops it
        wr(8'h04, 32'h02, "R5 ien on");
        chk(irq, 1, "R5 irq on enable");
        wr(8'h04, 32'h00, "R5 ien off");
        chk(irq, 0, "R5 irq off");
        wr(8'h00, 32'h41, "R2 thr wr 2");
        wr(8'h04, 32'h02, "R5 ien on busy");
        chk(irq, 0, "R5 no irq while busy");
        chk(tx_data, 8'h41, "R3 mask 8 data");
        ack_pulse();
        chk(irq, 1, "R4 irq on completion");
        rd(8'h08, 32'h02, "R4 ready code 2");

        // R6/R7 receive with interrupt enabled
        wr(8'h04, 32'h01, "R6 ien rx");
        chk(irq, 0, "R5 irq off by rx-only enable");
        rx_byte(8'h9C);
        chk(irq, 1, "R6 rx irq");
        rd(8'h14, 32'h21, "R6 rx ready");
        rd(8'h08, 32'h04, "R6 rx code");
        rd(8'h00, 32'h9C, "R7 rbr data");
        rd(8'h14, 32'h20, "R7 ready cleared");
        // R6 receive with interrupt disabled
        wr(8'h04, 32'h00, "R6 ien off");
        rx_byte(8'h33);
        chk(irq, 0, "R6 no irq when disabled");
        rd(8'h08, 32'h04, "R6 ident unchanged");
        rd(8'h14, 32'h21, "R6 ready set");
        rd(8'h00, 32'h33, "R7 rbr data 2");

        // R9 illegal accesses
        access(1'b1, 8'h0C, 4'h3, 32'h0, 32'h0, 1'b1, 1'b0, "R9 partial write");
        rd(8'h0C, 32'h03, "R9 lctl unchanged");
        access(1'b1, 8'h20, 4'hF, 32'h0, 32'h0, 1'b1, 1'b0, "R9 write past map");
        access(1'b0, 8'h1E, 4'hF, 32'h0, 32'h0, 1'b1, 1'b1, "R9 misaligned read");
        access(1'b0, 8'h40, 4'hF, 32'h0, 32'h0, 1'b1, 1'b1, "R9 read past map");
        access(1'b1, 8'h1C, 4'hE, 32'hAA, 32'h0, 1'b1, 1'b0, "R9 partial div write");
        rd(8'h1C, 32'h78, "R9 div unchanged");
        @(negedge clk);
        chk(bus_err, 0, "R9 error is one pulse");

        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int i = 0; i < WATCHDOG && !done; i++) @(negedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: run did not finish");
        end
        if (q_tag.size() != 0) begin
            n_vec++; n_bad++;
            $display("FAIL scoreboard: %0d expectations left", q_tag.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule